// File: doc/BRIEF.md
# Dual-Channel Serial DAC Code Loader

This block is the digital front end of a two-channel digital-to-analog converter. It receives a slow serial stream made of a serial clock, a data bit, an active-low shift-enable/load strobe and an active-low clear. All four pins are asynchronous to the fast system clock, so the block first passes them through a synchronizer. It then finds the edges of the serial clock and of the strobe on the synchronized copies.

While the strobe is low, each rising serial clock edge shifts one data bit into a frame register that holds two codes. When the strobe returns high, the frame is split and written into the channel A and channel B code registers in the same cycle. A one-cycle update pulse marks each such write. The last stage of the frame register is driven out as a serial output, so several devices can share one data line in a daisy chain. A low clear input holds both codes at zero.

Top module: `dual_dac_loader`

## Requirements
- R1: While the synchronized strobe `load_n_i` is low, every rising edge of `sclk_i` shifts the frame register left by one and places `sdin_i` in bit 0.
- R2: With exactly 2*CODE_W shifts in a frame, the first CODE_W bits sent form `code_a_o` and the next CODE_W bits form `code_b_o`. Each code is sent most significant bit first.
- R3: While `load_n_i` is high, edges on `sclk_i` leave the frame register unchanged. A load that follows with no shifts in between writes the earlier frame again.
- R4: On a rising edge of `load_n_i`, frame bits [2*CODE_W-1:CODE_W] go to `code_a_o` and bits [CODE_W-1:0] go to `code_b_o` in the same cycle. This holds for any number of shifts, whether fewer or more than 2*CODE_W.
- R5: While `clr_n_i` is low, both codes are zero, and a load in that period writes nothing. Clear does not alter the frame register.
- R6: `sdo_o` shows the top frame bit, which is the bit shifted in 2*CODE_W shifts earlier. It changes only on a shift.
- R7: After reset, both codes are zero, `sdo_o` is low and `upd_o` is low.
- R8: `upd_o` is high for exactly one system cycle for each load that is not blocked by clear. It is never high in two cycles in a row.
- R9: The codes change only on a load or a clear. Activity on `sdin_i` and `sclk_i` with the strobe high leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdin_i | input | 1 | Serial data bit |
| load_n_i | input | 1 | Active-low shift enable; its rising edge loads the codes |
| clr_n_i | input | 1 | Active-low clear of both codes |
| code_a_o | output | CODE_W | Channel A code |
| code_b_o | output | CODE_W | Channel B code |
| sdo_o | output | 1 | Cascade output, last stage of the frame register |
| upd_o | output | 1 | One-cycle pulse on each load that is not blocked |

## Verification
The bench builds the block with its default parameters: 12-bit codes and a two-stage synchronizer. At these values a full 24-bit frame is short enough to send many times, and every frame bit is covered. Serial phases last six system cycles, which is longer than the synchronizer and edge-detect latency, so each edge is seen exactly once. This makes it possible to test short frames, long frames, back-to-back frames for the daisy chain, and loads while clear is held low.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  // Bit positions of the four pins inside the shared synchronizer vector
  localparam int unsigned SIG_SCLK = 0;
  localparam int unsigned SIG_SDIN = 1;
  localparam int unsigned SIG_LOAD = 2;
  localparam int unsigned SIG_CLR  = 3;
  localparam int unsigned SIG_W    = 4;
  // Idle levels: strobe and clear are inactive high, clock and data low
  localparam logic [SIG_W-1:0] SIG_IDLE = 4'b1100;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dacif_rst_sync.sv
module dacif_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign frame_o = frame_q;
  assign sdo_o   = frame_q[FRAME_W-1];
endmodule

// File: rtl/dacif_coderegs.sv
module dacif_coderegs #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned FRAME_W = CODE_W * NUM_CH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clear,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] codes_o,
  output logic               upd_o
);
  logic upd_q;
  logic upd_d;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned HI = FRAME_W - 1 - ch * CODE_W;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;

    // Clear wins over a load in the same cycle
    always_comb begin
      code_d = code_q;
      if (clear)     code_d = '0;
      else if (load) code_d = frame_i[HI -: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
    end

    assign codes_o[HI -: CODE_W] = code_q;
  end

  always_comb upd_d = load & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacif_pkg::*;
#(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              load_n_i,
  input  logic              clr_n_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              sdo_o,
  output logic              upd_o
);
  localparam int unsigned FRAME_W = NUM_CH * CODE_W;

  logic               rst_n_s;
  logic [SIG_W-1:0]   pins_raw;
  logic [SIG_W-1:0]   pins_s;
  logic [1:0]         prev_q;
  logic [1:0]         prev_d;
  logic               load_lvl;
  logic               clear_lvl;
  logic               shift_pulse;
  logic               load_pulse;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] codes;

  dacif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_comb begin
    pins_raw           = '0;
    pins_raw[SIG_SCLK] = sclk_i;
    pins_raw[SIG_SDIN] = sdin_i;
    pins_raw[SIG_LOAD] = load_n_i;
    pins_raw[SIG_CLR]  = clr_n_i;
  end

  dacif_sync #(.W(SIG_W), .STAGES(SYNC_STAGES), .RST_VAL(SIG_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  // Edge detection: bit 0 follows the serial clock, bit 1 the strobe
  always_comb prev_d = {pins_s[SIG_LOAD], pins_s[SIG_SCLK]};

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) prev_q <= 2'b10;
    else          prev_q <= prev_d;
  end

  always_comb begin
    load_lvl    = pins_s[SIG_LOAD];
    clear_lvl   = ~pins_s[SIG_CLR];
    shift_pulse = pins_s[SIG_SCLK] & ~prev_q[0] & ~load_lvl;
    load_pulse  = load_lvl & ~prev_q[1];
  end

  dacif_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shift_en (shift_pulse),
    .din      (pins_s[SIG_SDIN]),
    .frame_o  (frame_q),
    .sdo_o    (sdo_o)
  );

  dacif_coderegs #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_codes (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (load_pulse),
    .clear   (clear_lvl),
    .frame_i (frame_q),
    .codes_o (codes),
    .upd_o   (upd_o)
  );

  assign code_a_o = codes[FRAME_W-1 -: CODE_W];
  assign code_b_o = codes[CODE_W-1:0];
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
  parameter int unsigned CODE_W = 12,
  localparam int unsigned FRAME_W = 2 * CODE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FRAME_W-1:0] frame,
  input logic               load_lvl,
  input logic               clear_lvl,
  input logic               shift_pulse,
  input logic [CODE_W-1:0]  code_a,
  input logic [CODE_W-1:0]  code_b,
  input logic               sdo,
  input logic               upd
);
  // R8
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  // R4
  load_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ({code_a, code_b} == frame));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_lvl |=> (code_a == '0 && code_b == '0 && !upd));

  // R3
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_lvl |=> $stable(frame));

  // R9
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(code_a) || !$stable(code_b)) |-> (upd || (code_a == '0 && code_b == '0)));

  // R6
  sdo_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(shift_pulse));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .frame       (frame_q),
  .load_lvl    (load_lvl),
  .clear_lvl   (clear_lvl),
  .shift_pulse (shift_pulse),
  .code_a      (code_a_o),
  .code_b      (code_b_o),
  .sdo         (sdo_o),
  .upd         (upd_o)
);

// File: tb/test_dual_dac_loader.sv
`timescale 1ns/1ps
module test_dual_dac_loader;
  localparam int CW = 12;
  localparam int FW = 2 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [CW-1:0] code_a, code_b;
  logic sdo, upd;

  logic [FW-1:0] model;
  logic [CW-1:0] exp_a, exp_b;
  int checks = 0, errors = 0, upd_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_dac_loader #(.CODE_W(CW), .SYNC_STAGES(2)) i_dual_dac_loader (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin),
    .load_n_i(load_n), .clr_n_i(clr_n), .code_a_o(code_a),
    .code_b_o(code_b), .sdo_o(sdo), .upd_o(upd)
  );

  always @(negedge clk) if (upd) upd_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Bench-side model of the expected codes for a given frame
  function automatic logic [CW-1:0] hi_code(logic [FW-1:0] f);
    return f[FW-1 -: CW];
  endfunction
  function automatic logic [CW-1:0] lo_code(logic [FW-1:0] f);
    return f[CW-1:0];
  endfunction

  task automatic pulse_sclk(logic b);
    sdin = b;
    wait_clk(6);
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    wait_clk(6);
    if (!load_n) model = {model[FW-2:0], b};
  endtask

  task automatic send_bits(logic [63:0] bits, int n, bit check_sdo);
    for (int i = n - 1; i >= 0; i--) begin
      pulse_sclk(bits[i]);
      if (check_sdo) chk("R6 sdo after shift", {31'd0, sdo}, {31'd0, model[FW-1]});
    end
  endtask

  task automatic open_frame();
    load_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic close_frame(string req);
    int c0;
    c0 = upd_cnt;
    load_n = 1'b1;
    wait_clk(10);
    exp_a = clr_n ? hi_code(model) : '0;
    exp_b = clr_n ? lo_code(model) : '0;
    chk({req, " code A"}, {20'd0, code_a}, {20'd0, exp_a});
    chk({req, " code B"}, {20'd0, code_b}, {20'd0, exp_b});
    chk("R8 update pulse count", upd_cnt - c0, clr_n ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] bits;
    logic [FW-1:0] first;
    logic [CW-1:0] ha, hb;
    void'($urandom(32'h1A2B3C4D));
    model = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);

    // R7 reset state
    chk("R7 code A reset", {20'd0, code_a}, 0);
    chk("R7 code B reset", {20'd0, code_b}, 0);
    chk("R7 sdo reset", {31'd0, sdo}, 0);
    chk("R7 upd reset", {31'd0, upd}, 0);

    // R1 R2 directed frame: A=0xA5C, B=0x3F1, MSB first
    open_frame();
    send_bits({40'd0, 12'hA5C, 12'h3F1}, FW, 1);
    close_frame("R2 directed");
    chk("R2 channel A value", {20'd0, code_a}, 32'hA5C);
    chk("R1 channel B value", {20'd0, code_b}, 32'h3F1);

    // R1 R2 random full frames
    for (int k = 0; k < 8; k++) begin
      bits = {$urandom(), $urandom()};
      open_frame();
      send_bits(bits, FW, 1);
      close_frame("R2 random frame");
    end

    // R4 short and long frames
    open_frame();
    send_bits({$urandom(), $urandom()}, 9, 1);
    close_frame("R4 short frame");
    open_frame();
    send_bits({$urandom(), $urandom()}, 37, 1);
    close_frame("R4 long frame");
    for (int k = 0; k < 4; k++) begin
      int n;
      n = 4 + int'($urandom_range(40));
      open_frame();
      send_bits({$urandom(), $urandom()}, n, 1);
      close_frame("R4 random length");
    end

    // R6 daisy chain: second frame pushes the first out of sdo
    first = FW'({$urandom(), $urandom()});
    open_frame();
    send_bits({40'd0, first}, FW, 0);
    for (int i = FW - 1; i >= 0; i--) begin
      chk("R6 cascade bit", {31'd0, sdo}, {31'd0, first[i]});
      pulse_sclk(1'($urandom()));
    end
    close_frame("R6 after chain");

    // R3 R9 clock and data activity with strobe high
    ha = code_a; hb = code_b;
    begin
      int c0;
      c0 = upd_cnt;
      send_bits({$urandom(), $urandom()}, 10, 0);
      chk("R9 code A unchanged", {20'd0, code_a}, {20'd0, ha});
      chk("R9 code B unchanged", {20'd0, code_b}, {20'd0, hb});
      chk("R9 no update", upd_cnt - c0, 0);
    end
    open_frame();
    close_frame("R3 reload without shifts");

    // R5 clear holds zero, blocks load, keeps frame
    first = model;
    clr_n = 1'b0;
    wait_clk(6);
    chk("R5 clear code A", {20'd0, code_a}, 0);
    chk("R5 clear code B", {20'd0, code_b}, 0);
    open_frame();
    close_frame("R5 load during clear");
    clr_n = 1'b1;
    wait_clk(6);
    chk("R5 codes stay zero after release", {20'd0, code_a}, 0);
    open_frame();
    close_frame("R5 frame kept through clear");
    chk("R5 frame intact", {20'd0, code_a}, {20'd0, hi_code(first)});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule